// File: doc/BRIEF.md
# Lockable Direct-Mapped Instruction Cache with Side Line Buffer

This block is an instruction cache for processors that must have execution times known in advance. Software first clears the cache. It then places the blocks it has chosen, one at a time, with explicit fill commands, and freezes the whole array with a single lock command. While the array is frozen, no fetch can evict or allocate anything. A fetch that misses is served from main memory, and the 16-byte block it belongs to is kept in a single-line side buffer. Later words of that block therefore return at hit speed.

When the cache is unlocked it behaves as a plain direct-mapped cache: a miss allocates the line it maps to, and the side buffer is neither read nor written. Fetches arrive as single-cycle request pulses carrying a word address. Each answer comes back as a one-cycle ready pulse with the instruction word. The cache talks to memory through a request pulse carrying a block address, and memory returns a whole 128-bit line later.

Top module: `lockable_icache`

## Requirements
- R1: After reset, no cache line and no buffer entry is valid and the cache is unlocked. In that state `busy_o`, `fetch_rdy_o` and `mem_req_o` are all low.
- R2: An idle-cycle fetch whose block is held in a valid cache line raises `fetch_rdy_o` in the next cycle with the addressed word, and no memory request is made. Address bits [3:2] pick the word, with word k in bits [32k+31:32k] of the line. The index is `fetch_addr_i[4+:log2(LINES)]` and the remaining upper bits form the tag.
- R3: While the cache is locked, a fetch that misses the array but matches the side buffer is answered with the same one-cycle latency as R2.
- R4: While the cache is locked, a fetch that misses both the array and the buffer issues a one-cycle `mem_req_o` carrying the block address (fetch address bits above bit 3). The word is returned in the cycle after `mem_rvalid_i`. The line replaces the buffer contents, and no cache line changes.
- R5: While the cache is unlocked, the side buffer is ignored. A miss fetches the block as in R4, writes it into the line it maps to, and returns the word in the cycle after `mem_rvalid_i`.
- R6: Command code 0 (fill) fetches the block named on `cmd_blk_i` and writes it into its mapped line, whether the cache is locked or not. A fill produces no fetch response.
- R7: Command code 1 locks the cache and code 2 unlocks it. The change applies to the next accepted fetch.
- R8: Command code 3 (flush) invalidates every cache line and the side buffer, and leaves the lock state as it was.
- R9: From the cycle after a miss or fill is accepted until the cycle in which `mem_rvalid_i` is seen, `busy_o` is high. During that time fetch requests and commands are dropped and `mem_addr_o` is held.
- R10: If a fetch and a command arrive in the same idle cycle, the fetch is served and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | One-cycle fetch request |
| fetch_addr_i | input | AW-2 | Word address of the instruction |
| fetch_rdy_o | output | 1 | Instruction word valid |
| fetch_data_o | output | 32 | Instruction word |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 2 | 0 fill, 1 lock, 2 unlock, 3 flush |
| cmd_blk_i | input | AW-4 | Block address for fill |
| busy_o | output | 1 | Memory transfer outstanding; inputs are dropped |
| mem_req_o | output | 1 | One-cycle line read request |
| mem_addr_o | output | AW-4 | Block address of the read |
| mem_rvalid_i | input | 1 | Line data valid |
| mem_rdata_i | input | 128 | Line data, word 0 in the low bits |

## Verification
The hardest case to reach is a locked miss whose block maps onto a line that was placed by a fill. That miss must go through the buffer, and the pinned line must survive it. The stimulus fills two blocks, locks the cache, and then fetches a conflicting block, its later words, the original block again, and a second conflicting block. A same-cycle fetch-plus-unlock pair and inputs sent during a transfer are used to show that the lock survives the commands that were dropped. A behavioural model tracks expected latency and data on every clock.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WPL    = 4;
  localparam int unsigned LINE_W = WORD_W * WPL;

  typedef enum logic [1:0] {
    CMD_FILL   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2,
    CMD_FLUSH  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MISS,
    ST_FILL
  } st_e;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_CACHE,
    RSP_BUF,
    RSP_MEM
  } rsp_e;
endpackage

// File: rtl/lic_line_store.sv
module lic_line_store
  import lic_pkg::*;
#(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAGW  = 24,
  localparam int unsigned IDXW = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDXW-1:0]   rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAGW-1:0]   rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              we_i,
  input  logic [IDXW-1:0]   wr_idx_i,
  input  logic [TAGW-1:0]   wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              flush_i
);
  logic [LINES-1:0] valid_w;
  logic [TAGW-1:0]   tag_w  [LINES];
  logic [LINE_W-1:0] data_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic [TAGW-1:0]   t_q;
    logic [LINE_W-1:0] d_q;
    logic              hit_wr;
    assign hit_wr = we_i && (wr_idx_i == IDXW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     v_q <= 1'b0;
      else if (flush_i) v_q <= 1'b0;
      else if (hit_wr)  v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit_wr) begin
        t_q <= wr_tag_i;
        d_q <= wr_line_i;
      end
    end

    assign valid_w[g] = v_q;
    assign tag_w[g]   = t_q;
    assign data_w[g]  = d_q;
  end

  assign rd_valid_o = valid_w[rd_idx_i];
  assign rd_tag_o   = tag_w[rd_idx_i];
  assign rd_line_o  = data_w[rd_idx_i];
endmodule

// File: rtl/lic_line_buf.sv
module lic_line_buf
  import lic_pkg::*;
#(
  parameter int unsigned BLKW = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLKW-1:0]   look_blk_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              we_i,
  input  logic [BLKW-1:0]   wr_blk_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              flush_i
);
  logic              v_q;
  logic [BLKW-1:0]   blk_q;
  logic [LINE_W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     v_q <= 1'b0;
    else if (flush_i) v_q <= 1'b0;
    else if (we_i)    v_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      blk_q <= wr_blk_i;
      d_q   <= wr_line_i;
    end
  end

  assign hit_o  = v_q && (blk_q == look_blk_i);
  assign line_o = d_q;
endmodule

// File: rtl/lic_ctrl.sv
module lic_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned BLKW = 28
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_req_i,
  input  logic [BLKW-1:0] fetch_blk_i,
  input  logic [1:0]      fetch_word_i,
  input  logic            cache_hit_i,
  input  logic            buf_hit_i,
  input  logic            cmd_valid_i,
  input  cmd_e            cmd_op_i,
  input  logic [BLKW-1:0] cmd_blk_i,
  input  logic            mem_rvalid_i,
  output logic            busy_o,
  output logic            filling_o,
  output logic            mem_req_o,
  output logic [BLKW-1:0] mem_blk_o,
  output logic            lock_o,
  output logic            flush_o,
  output logic            line_we_o,
  output logic            buf_we_o,
  output rsp_e            rsp_src_o,
  output logic [1:0]      rsp_word_o
);
  st_e             st_q;
  logic            mem_req_q, lock_q;
  logic [BLKW-1:0] pend_blk_q;
  logic [1:0]      pend_word_q;

  logic idle, take_fetch, take_cmd, fetch_miss, start_fill, done;

  assign idle       = (st_q == ST_IDLE);
  assign take_fetch = idle && fetch_req_i;
  assign take_cmd   = idle && !fetch_req_i && cmd_valid_i;  // fetch wins a tie
  assign fetch_miss = take_fetch && !cache_hit_i && !(lock_q && buf_hit_i);
  assign start_fill = take_cmd && (cmd_op_i == CMD_FILL);
  assign done       = !idle && mem_rvalid_i;

  assign flush_o   = take_cmd && (cmd_op_i == CMD_FLUSH);
  assign line_we_o = done && ((st_q == ST_FILL) || !lock_q);
  assign buf_we_o  = done && (st_q == ST_MISS) && lock_q;

  always_comb begin
    rsp_src_o  = RSP_NONE;
    rsp_word_o = fetch_word_i;
    if (take_fetch && cache_hit_i)            rsp_src_o = RSP_CACHE;
    else if (take_fetch && lock_q && buf_hit_i) rsp_src_o = RSP_BUF;
    else if (done && st_q == ST_MISS) begin
      rsp_src_o  = RSP_MEM;
      rsp_word_o = pend_word_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mem_req_q   <= 1'b0;
      lock_q      <= 1'b0;
      pend_blk_q  <= '0;
      pend_word_q <= '0;
    end else begin
      mem_req_q <= fetch_miss || start_fill;
      if (fetch_miss) begin
        st_q        <= ST_MISS;
        pend_blk_q  <= fetch_blk_i;
        pend_word_q <= fetch_word_i;
      end else if (start_fill) begin
        st_q       <= ST_FILL;
        pend_blk_q <= cmd_blk_i;
      end else if (done) begin
        st_q <= ST_IDLE;
      end
      if (take_cmd && cmd_op_i == CMD_LOCK)   lock_q <= 1'b1;
      if (take_cmd && cmd_op_i == CMD_UNLOCK) lock_q <= 1'b0;
    end
  end

  assign busy_o    = !idle;
  assign filling_o = (st_q == ST_FILL);
  assign mem_req_o = mem_req_q;
  assign mem_blk_o = pend_blk_q;
  assign lock_o    = lock_q;
endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import lic_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LINES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [AW-1:2]     fetch_addr_i,
  output logic              fetch_rdy_o,
  output logic [WORD_W-1:0] fetch_data_o,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [AW-1:4]     cmd_blk_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [AW-1:4]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  localparam int unsigned BLKW = AW - 4;
  localparam int unsigned IDXW = $clog2(LINES);
  localparam int unsigned TAGW = BLKW - IDXW;

  logic [BLKW-1:0]   fetch_blk, mem_blk;
  logic [1:0]        fetch_word, rsp_word;
  logic              st_valid, cache_hit, buf_hit;
  logic [TAGW-1:0]   st_tag;
  logic [LINE_W-1:0] st_line, buf_line, line_sel;
  logic              lock_w, flush_w, line_we, buf_we, filling;
  rsp_e              rsp_src;
  logic [WPL-1:0][WORD_W-1:0] words;
  logic              rdy_q;
  logic [WORD_W-1:0] data_q;

  assign fetch_blk  = fetch_addr_i[AW-1:4];
  assign fetch_word = fetch_addr_i[3:2];

  lic_line_store #(.LINES(LINES), .TAGW(TAGW)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i  (fetch_blk[IDXW-1:0]),
    .rd_valid_o(st_valid),
    .rd_tag_o  (st_tag),
    .rd_line_o (st_line),
    .we_i      (line_we),
    .wr_idx_i  (mem_blk[IDXW-1:0]),
    .wr_tag_i  (mem_blk[BLKW-1:IDXW]),
    .wr_line_i (mem_rdata_i),
    .flush_i   (flush_w)
  );

  assign cache_hit = st_valid && (st_tag == fetch_blk[BLKW-1:IDXW]);

  lic_line_buf #(.BLKW(BLKW)) u_buf (
    .clk_i, .rst_ni,
    .look_blk_i(fetch_blk),
    .hit_o     (buf_hit),
    .line_o    (buf_line),
    .we_i      (buf_we),
    .wr_blk_i  (mem_blk),
    .wr_line_i (mem_rdata_i),
    .flush_i   (flush_w)
  );

  lic_ctrl #(.BLKW(BLKW)) u_ctrl (
    .clk_i, .rst_ni,
    .fetch_req_i,
    .fetch_blk_i (fetch_blk),
    .fetch_word_i(fetch_word),
    .cache_hit_i (cache_hit),
    .buf_hit_i   (buf_hit),
    .cmd_valid_i,
    .cmd_op_i    (cmd_e'(cmd_op_i)),
    .cmd_blk_i,
    .mem_rvalid_i,
    .busy_o,
    .filling_o   (filling),
    .mem_req_o,
    .mem_blk_o   (mem_blk),
    .lock_o      (lock_w),
    .flush_o     (flush_w),
    .line_we_o   (line_we),
    .buf_we_o    (buf_we),
    .rsp_src_o   (rsp_src),
    .rsp_word_o  (rsp_word)
  );

  always_comb begin
    unique case (rsp_src)
      RSP_CACHE: line_sel = st_line;
      RSP_BUF:   line_sel = buf_line;
      RSP_MEM:   line_sel = mem_rdata_i;
      default:   line_sel = '0;
    endcase
  end
  assign words = line_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rdy_q <= (rsp_src != RSP_NONE);
      if (rsp_src != RSP_NONE) data_q <= words[rsp_word];
    end
  end

  assign fetch_rdy_o  = rdy_q;
  assign fetch_data_o = data_q;
  assign mem_addr_o   = mem_blk;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int unsigned BLKW = 28
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_rdy_i,
  input logic            busy_i,
  input logic            mem_req_i,
  input logic [BLKW-1:0] mem_addr_i,
  input logic            mem_rvalid_i,
  input logic            lock_i,
  input logic            line_we_i,
  input logic            fill_i
);
  p_memreq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |=> !mem_req_i);

  p_memreq_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> busy_i);

  p_no_rdy_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !fetch_rdy_i);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mem_addr_i));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && mem_rvalid_i) |=> !busy_i);

  p_lock_no_alloc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && line_we_i) |-> fill_i);

  p_fill_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && mem_rvalid_i) |=> !fetch_rdy_i);
endmodule

bind lockable_icache lic_checker #(.BLKW(AW - 4)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_rdy_i (fetch_rdy_o),
  .busy_i      (busy_o),
  .mem_req_i   (mem_req_o),
  .mem_addr_i  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .lock_i      (lock_w),
  .line_we_i   (line_we),
  .fill_i      (filling)
);

// File: tb/tb_lockable_icache.sv
module tb_lockable_icache;
  localparam int AW    = 32;
  localparam int LINES = 16;
  localparam int LAT   = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_req = 1'b0;
  logic [AW-1:2] fetch_addr = '0;
  logic         fetch_rdy;
  logic [31:0]  fetch_data;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = '0;
  logic [AW-1:4] cmd_blk = '0;
  logic         busy, mem_req;
  logic [AW-1:4] mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [127:0] mem_rdata = '0;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  lockable_icache #(.AW(AW), .LINES(LINES)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .fetch_rdy_o(fetch_rdy), .fetch_data_o(fetch_data),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_blk_i(cmd_blk),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mword(int blk, int w);
    logic [31:0] k;
    k = 32'(blk * 4 + w);
    return (k * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  // memory model
  int mcnt = 0;
  int mblk = 0;
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    if (mcnt > 0) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) begin
        mem_rvalid <= 1'b1;
        for (int w = 0; w < 4; w++) mem_rdata[32*w +: 32] <= mword(mblk, w);
      end
    end
    if (mem_req) begin
      mcnt = LAT;
      mblk = int'(mem_addr);
    end
  end

  // reference model
  bit    m_v[LINES];
  int    m_tag[LINES];
  bit    m_lock, b_v;
  int    b_blk, m_st, p_blk, p_word;
  bit    e_rdy, e_req;
  logic [31:0] e_data;
  int    e_addr;
  string m_rq = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_lock = 0; b_v = 0; m_st = 0; e_rdy = 0; e_req = 0; e_data = 0;
      e_addr = 0; m_rq = "R1";
    end else begin
      int blk, idx, tg, w;
      e_rdy = 0; e_req = 0;
      if (m_st == 0) begin
        if (fetch_req) begin
          blk = int'(fetch_addr[AW-1:4]); w = int'(fetch_addr[3:2]);
          idx = blk % LINES; tg = blk / LINES;
          if (cmd_valid) m_rq = "R10";
          if (m_v[idx] && m_tag[idx] == tg) begin
            e_rdy = 1; e_data = mword(blk, w); if (!cmd_valid) m_rq = "R2";
          end else if (m_lock && b_v && b_blk == blk) begin
            e_rdy = 1; e_data = mword(blk, w); if (!cmd_valid) m_rq = "R3";
          end else begin
            m_st = 1; p_blk = blk; p_word = w; e_req = 1; e_addr = blk;
            if (!cmd_valid) m_rq = m_lock ? "R4" : "R5";
          end
        end else if (cmd_valid) begin
          case (cmd_op)
            2'd0: begin m_st = 2; p_blk = int'(cmd_blk); e_req = 1; e_addr = p_blk; m_rq = "R6"; end
            2'd1: begin m_lock = 1; m_rq = "R7"; end
            2'd2: begin m_lock = 0; m_rq = "R7"; end
            default: begin foreach (m_v[i]) m_v[i] = 0; b_v = 0; m_rq = "R8"; end
          endcase
        end
      end else begin
        if (fetch_req || cmd_valid) m_rq = "R9";
        if (mem_rvalid) begin
          idx = p_blk % LINES;
          if (m_st == 1) begin
            if (m_lock) begin b_v = 1; b_blk = p_blk; end
            else begin m_v[idx] = 1; m_tag[idx] = p_blk / LINES; end
            e_rdy = 1; e_data = mword(p_blk, p_word);
          end else begin
            m_v[idx] = 1; m_tag[idx] = p_blk / LINES;
          end
          m_st = 0;
        end
      end
    end
  end

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_rq, "fetch_rdy", 64'(fetch_rdy), 64'(e_rdy));
      if (e_rdy) chk(m_rq, "fetch_data", 64'(fetch_data), 64'(e_data));
      chk(m_rq, "busy", 64'(busy), 64'(m_st != 0));
      chk(m_rq, "mem_req", 64'(mem_req), 64'(e_req));
      if (e_req) chk(m_rq, "mem_addr", 64'(mem_addr), 64'(e_addr));
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      report();
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk); wait_idle();
    fetch_req = 1; fetch_addr = a[AW-1:2];
    @(negedge clk); fetch_req = 0;
    wait_idle();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk); wait_idle();
    cmd_valid = 1; cmd_op = op; cmd_blk = a[AW-1:4];
    @(negedge clk); cmd_valid = 0;
    wait_idle();
  endtask

  localparam logic [31:0] A = 32'h1040, B = 32'h2040, X = 32'h3000, Y = 32'h3010;
  localparam logic [31:0] Z = 32'h5000, W = 32'h5020, V = 32'h7030;

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during and just after reset
    chk("R1", "reset busy", 64'(busy), 64'd0);
    chk("R1", "reset rdy", 64'(fetch_rdy), 64'd0);
    chk("R1", "reset mem_req", 64'(mem_req), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset busy", 64'(busy), 64'd0);
    // R5 unlocked misses allocate, R2 hits
    fetch(A); fetch(A + 4); fetch(A + 12);
    fetch(B); fetch(A); fetch(A + 8); fetch(B);
    // R8 flush then miss
    cmd(2'd3, 0); fetch(A);
    // R6 fills, R7 lock, R3/R4 buffer path
    cmd(2'd3, 0); cmd(2'd0, X); cmd(2'd0, Y); cmd(2'd1, 0);
    fetch(X + 4); fetch(Y + 8);
    fetch(Z); fetch(Z + 4); fetch(Z + 12);
    fetch(X); fetch(W); fetch(Z); fetch(X + 8);
    cmd(2'd0, V); fetch(V + 4);
    // R9: inputs during a transfer are dropped
    @(negedge clk); wait_idle();
    fetch_req = 1; fetch_addr = W[AW-1:2];
    @(negedge clk); fetch_req = 0;
    repeat (2) @(negedge clk);
    fetch_req = 1; fetch_addr = X[AW-1:2];
    @(negedge clk); fetch_req = 0; cmd_valid = 1; cmd_op = 2'd2;
    @(negedge clk); cmd_valid = 0; cmd_op = 2'd3;
    wait_idle();
    fetch(X); fetch(W + 4);
    // R10: fetch beats a same-cycle unlock
    @(negedge clk); wait_idle();
    fetch_req = 1; fetch_addr = X[AW-1:2]; cmd_valid = 1; cmd_op = 2'd2;
    @(negedge clk); fetch_req = 0; cmd_valid = 0;
    fetch(Z); fetch(Z + 8);
    // R7 unlock: buffer ignored, R5 allocation
    cmd(2'd2, 0);
    fetch(Z + 8); fetch(W + 8); fetch(W); fetch(X);
    // R8 flush keeps lock, clears buffer
    cmd(2'd1, 0); fetch(W); cmd(2'd3, 0);
    fetch(W + 4); fetch(W + 8); fetch(Z); fetch(Z + 4);
    repeat (4) @(negedge clk);
    report();
  end
endmodule